// File: doc/BRIEF.md
# Key-Sequence Protected Clock-Switch Register

This block is a small write-protected control register for an oscillator switch. It sits on a byte-wide register bus. A per-cycle access strobe marks each bus access, so back-to-back accesses have a precise meaning. The register has two byte lanes. The high lane holds a 3-bit field that selects the next oscillator. The low lane holds a switch-enable bit and a read-only status bit that shows whether the PLL is locked.

Neither lane accepts an ordinary write. Each lane has its own two-key sequence, written in two consecutive accesses to that lane. Once the sequence completes, the lane accepts exactly one more access and then locks again.

Setting the switch-enable bit sends a one-cycle request, carrying the latched select value, to an external clock switcher. The switcher answers with a done pulse, which clears the enable bit. It may answer with a fail pulse instead, which leaves the enable bit set. Software then reads the lock status bit to find the cause.

Top module: `clksel_guard`

## Requirements
- R1: The high lane (`hi_sel`=1) opens only after the key 0x78 and then the key 0x9A are written to it in consecutive accesses. The next access may then write the select field, which is `wdata[2:0]` and reads back as `rdata[2:0]`.
- R2: The low lane (`hi_sel`=0) opens only after the key 0x46 and then the key 0x57 are written to it in consecutive accesses. A write in the next access with `wdata[0]`=1 then sets the switch-enable bit, which reads back as `rdata[0]`.
- R3: An open lane accepts exactly one access. Any later write to that lane is ignored until the lane is unlocked again.
- R4: Any access that breaks a key sequence returns that lane's checker to idle. This covers a read, a write to the other lane, and a wrong value. Cycles with `acc`=0 are not accesses and leave the checker state unchanged.
- R5: The second key alone does not unlock a lane. Writing the first key twice in a row leaves the checker waiting for the second key.
- R6: Writes to a locked lane, including the key writes themselves, do not change the register contents.
- R7: When the switch-enable bit is set and no switch is pending, `sw_req` is high for exactly one cycle, the cycle after the accepted write. `sw_sel` carries the select value held at that time.
- R8: `sw_done` during a pending switch clears the enable bit. `sw_fail` ends the pending switch but leaves the enable bit set, so a later unlocked set issues a new request.
- R9: Low lane `rdata[3]` shows `pll_lock` delayed by one clock.
- R10: After reset the select field is 0, the enable bit is 0, `sw_req` is low and both checkers are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc | input | 1 | Bus access strobe for this cycle |
| wr | input | 1 | Access is a write (valid with `acc`) |
| hi_sel | input | 1 | Lane select: 1 = high lane, 0 = low lane |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the lane picked by `hi_sel` |
| sw_req | output | 1 | One-cycle switch request |
| sw_sel | output | 3 | Oscillator select sent with the request |
| sw_done | input | 1 | Switcher reports success |
| sw_fail | input | 1 | Switcher reports failure |
| pll_lock | input | 1 | PLL lock indication |

## Verification
Some behaviour can be checked on every cycle. The select field holds still unless there is a high-lane write. A request pulse lasts one cycle and coincides with a pending, enabled switch. Done clears the enable bit, fail keeps it set, and the lock bit trails `pll_lock` by one clock.

Other behaviour needs the bench's scenarios. These cover which access sequences open a lane: a broken sequence, a repeated first key, a lone second key, and idle cycles between keys. They also cover the single-access window, the select value carried by the request, and the retry after a failure.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_KEY1 = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_t;
endpackage

// File: rtl/lane_unlock.sv
module lane_unlock
  import clksel_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [DW-1:0] KEY_A = '0,
  parameter logic [DW-1:0] KEY_B = '0,
  parameter bit          LANE_HI = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_acc,
  input  logic          bus_wr,
  input  logic          bus_hi,
  input  logic [DW-1:0] bus_data,
  output logic          window
);
  lk_state_t st_q, st_d;
  logic      hit;

  assign hit = bus_acc && bus_wr && (bus_hi == LANE_HI);

  // next-state: only real accesses move the checker
  always_comb begin
    st_d = st_q;
    if (bus_acc) begin
      case (st_q)
        LK_IDLE: st_d = (hit && bus_data == KEY_A) ? LK_KEY1 : LK_IDLE;
        LK_KEY1: begin
          if (hit && bus_data == KEY_B)      st_d = LK_OPEN;
          else if (hit && bus_data == KEY_A) st_d = LK_KEY1;
          else                               st_d = LK_IDLE;
        end
        LK_OPEN: st_d = LK_IDLE;
        default: st_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign window = (st_q == LK_OPEN);
endmodule

// File: rtl/switch_ctrl.sv
module switch_ctrl #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             done,
  input  logic             fail,
  output logic             swen,
  output logic             pending,
  output logic             req,
  output logic [SEL_W-1:0] req_sel
);
  logic             swen_d, pend_d, req_d;
  logic [SEL_W-1:0] rsel_d;

  always_comb begin
    swen_d = swen;
    pend_d = pending;
    req_d  = 1'b0;
    rsel_d = req_sel;
    if (set_en && !pending) begin
      swen_d = 1'b1;
      pend_d = 1'b1;
      req_d  = 1'b1;
      rsel_d = sel_in;
    end else if (pending && done) begin
      swen_d = 1'b0;
      pend_d = 1'b0;
    end else if (pending && fail) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swen    <= 1'b0;
      pending <= 1'b0;
      req     <= 1'b0;
      req_sel <= '0;
    end else begin
      swen    <= swen_d;
      pending <= pend_d;
      req     <= req_d;
      req_sel <= rsel_d;
    end
  end
endmodule

// File: rtl/clksel_guard.sv
module clksel_guard #(
  parameter int DW       = 8,
  parameter int SEL_W    = 3,
  parameter int EN_BIT   = 0,
  parameter int LOCK_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             wr,
  input  logic             hi_sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             sw_req,
  output logic [SEL_W-1:0] sw_sel,
  input  logic             sw_done,
  input  logic             sw_fail,
  input  logic             pll_lock
);
  localparam int NLANE = 2;
  localparam logic [DW-1:0] KA [NLANE] = '{8'h46, 8'h78};
  localparam logic [DW-1:0] KB [NLANE] = '{8'h57, 8'h9A};

  logic [1:0]       rsync_q;
  logic             rst_q;
  logic [NLANE-1:0] win;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en, set_en;
  logic             lock_q;
  logic             swen, pending;
  logic [DW-1:0]    lo_v;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // lane 0 = low byte, lane 1 = high byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    lane_unlock #(
      .DW(DW), .KEY_A(KA[g]), .KEY_B(KB[g]), .LANE_HI(g == 1)
    ) u_lane (
      .clk(clk), .rst_n(rst_q), .bus_acc(acc), .bus_wr(wr),
      .bus_hi(hi_sel), .bus_data(wdata), .window(win[g])
    );
  end

  assign sel_en = acc && wr && hi_sel && win[1];
  assign set_en = acc && wr && !hi_sel && win[0] && wdata[EN_BIT];

  always_comb begin
    sel_d = sel_q;
    if (sel_en) sel_d = wdata[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sel_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      lock_q <= pll_lock;
    end
  end

  switch_ctrl #(.SEL_W(SEL_W)) u_sw (
    .clk(clk), .rst_n(rst_q), .set_en(set_en), .sel_in(sel_q),
    .done(sw_done), .fail(sw_fail), .swen(swen), .pending(pending),
    .req(sw_req), .req_sel(sw_sel)
  );

  always_comb begin
    lo_v           = '0;
    lo_v[EN_BIT]   = swen;
    lo_v[LOCK_BIT] = lock_q;
  end

  assign rdata = hi_sel ? {{(DW-SEL_W){1'b0}}, sel_q} : lo_v;
endmodule

// File: rtl/clksel_guard_chk.sv
module clksel_guard_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             wr,
  input logic             hi_sel,
  input logic [SEL_W-1:0] sel,
  input logic             swen,
  input logic             pending,
  input logic             sw_req,
  input logic             sw_done,
  input logic             sw_fail,
  input logic             pll_lock,
  input logic             lock_q
);
  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && wr && hi_sel) |=> $stable(sel));

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !sw_req);

  assert_req_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |-> (swen && pending));

  assert_en_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(swen) |-> sw_req);

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && sw_done) |=> (!swen && !pending));

  assert_fail_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && sw_fail && !sw_done) |=> swen);

  assert_lock_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (lock_q == $past(pll_lock)));
endmodule

bind clksel_guard clksel_guard_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .acc(acc), .wr(wr), .hi_sel(hi_sel),
  .sel(sel_q), .swen(swen), .pending(pending), .sw_req(sw_req),
  .sw_done(sw_done), .sw_fail(sw_fail), .pll_lock(pll_lock), .lock_q(lock_q)
);

// File: tb/clksel_guard_tb.sv
module clksel_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       acc, wr, hi_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       sw_req;
  logic [2:0] sw_sel;
  logic       sw_done, sw_fail, pll_lock;
  int         n_chk = 0;
  int         n_bad = 0;
  logic       finished = 1'b0;

  always #4 clk = ~clk;

  clksel_guard u_dut (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(wr), .hi_sel(hi_sel),
    .wdata(wdata), .rdata(rdata), .sw_req(sw_req), .sw_sel(sw_sel),
    .sw_done(sw_done), .sw_fail(sw_fail), .pll_lock(pll_lock)
  );

  // {acc, wr, hi, data[7:0], expected select after the access}
  localparam int NV = 27;
  localparam logic [13:0] VEC [NV] = '{
    {3'b111, 8'h05, 3'd0},  // R6 locked write ignored
    {3'b111, 8'h78, 3'd0},
    {3'b111, 8'h9A, 3'd0},  // R6 keys do not modify
    {3'b111, 8'h05, 3'd5},  // R1 window write
    {3'b111, 8'h03, 3'd5},  // R3 second write ignored
    {3'b111, 8'h78, 3'd5},
    {3'b101, 8'h00, 3'd5},  // R4 read breaks sequence
    {3'b111, 8'h9A, 3'd5},
    {3'b111, 8'h02, 3'd5},
    {3'b111, 8'h9A, 3'd5},  // R5 lone second key
    {3'b111, 8'h02, 3'd5},
    {3'b111, 8'h78, 3'd5},
    {3'b111, 8'h78, 3'd5},  // R5 first key twice
    {3'b111, 8'h9A, 3'd5},
    {3'b111, 8'h06, 3'd6},
    {3'b111, 8'h78, 3'd6},
    {3'b110, 8'h46, 3'd6},  // R4 other lane write
    {3'b111, 8'h9A, 3'd6},
    {3'b111, 8'h01, 3'd6},
    {3'b111, 8'h78, 3'd6},
    {3'b000, 8'h00, 3'd6},  // R4 idle cycle holds state
    {3'b111, 8'h9A, 3'd6},
    {3'b111, 8'h01, 3'd1},
    {3'b111, 8'h78, 3'd1},
    {3'b111, 8'h55, 3'd1},  // R4 wrong value
    {3'b111, 8'h9A, 3'd1},
    {3'b111, 8'h04, 3'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus cycle, then return at the next falling edge with the bus idle
  task automatic op(input logic a, input logic w, input logic h, input logic [7:0] d);
    @(negedge clk);
    acc = a; wr = w; hi_sel = h; wdata = d;
    @(negedge clk);
    acc = 1'b0; wr = 1'b0;
  endtask

  task automatic rd(input logic h, output logic [7:0] v);
    hi_sel = h;
    #1;
    v = rdata;
  endtask

  task automatic pulse_done(input logic is_fail);
    @(negedge clk);
    if (is_fail) sw_fail = 1'b1; else sw_done = 1'b1;
    @(negedge clk);
    sw_fail = 1'b0; sw_done = 1'b0;
  endtask

  task automatic unlock_lo();
    op(1'b1, 1'b1, 1'b0, 8'h46);
    op(1'b1, 1'b1, 1'b0, 8'h57);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; acc = 1'b0; wr = 1'b0; hi_sel = 1'b1; wdata = '0;
    sw_done = 1'b0; sw_fail = 1'b0; pll_lock = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    rd(1'b1, v); check("R10 select", v, 0);
    rd(1'b0, v); check("R10 low lane", v, 0);
    check("R10 sw_req", sw_req, 0);

    // vector walk over the high lane
    for (int i = 0; i < NV; i++) begin
      op(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:3]);
      rd(1'b1, v);
      check($sformatf("R1/R3/R4/R5/R6 vec%0d", i), v, VEC[i][2:0]);
    end

    // R6 locked low write does nothing
    op(1'b1, 1'b1, 1'b0, 8'h01);
    check("R6 no request", sw_req, 0);
    rd(1'b0, v); check("R6 enable stays", v, 0);

    // R2 / R7 set enable after low unlock
    unlock_lo();
    op(1'b1, 1'b1, 1'b0, 8'h01);
    check("R7 request pulse", sw_req, 1);
    check("R7 request select", sw_sel, 1);
    rd(1'b0, v); check("R2 enable set", v[0], 1);
    @(negedge clk);
    check("R7 single cycle", sw_req, 0);

    // R8 done clears
    pulse_done(1'b0);
    rd(1'b0, v); check("R8 done clears", v[0], 0);

    // R3 low window one access only
    unlock_lo();
    op(1'b1, 1'b1, 1'b0, 8'h00);
    op(1'b1, 1'b1, 1'b0, 8'h01);
    check("R3 no request", sw_req, 0);
    rd(1'b0, v); check("R3 low ignored", v[0], 0);

    // R8 fail keeps bit, retry requests again
    unlock_lo();
    op(1'b1, 1'b1, 1'b0, 8'h01);
    check("R8 first request", sw_req, 1);
    pulse_done(1'b1);
    rd(1'b0, v); check("R8 fail keeps enable", v[0], 1);
    unlock_lo();
    op(1'b1, 1'b1, 1'b0, 8'h01);
    check("R8 retry request", sw_req, 1);
    pulse_done(1'b0);
    rd(1'b0, v); check("R8 retry done", v[0], 0);

    // R9 lock status
    @(negedge clk); pll_lock = 1'b1;
    @(negedge clk);
    rd(1'b0, v); check("R9 lock high", v[3], 1);
    pll_lock = 1'b0;
    @(negedge clk);
    rd(1'b0, v); check("R9 lock low", v[3], 0);

    // R10 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1'b1, v); check("R10 select after reset", v, 0);

    finished = 1'b1;
    finish_run();
  end
endmodule